// File: doc/BRIEF.md
# Aperture Page Remapper

This block lets bus masters use a contiguous window of bus addresses (the aperture) whose 4 KiB pages are scattered anywhere in physical memory. A table inside the block holds one entry per aperture page. Each entry carries a valid flag in bit 31 and a physical page frame in bits 30:12. Software reaches the table only indirectly. It first places an aperture address in a pointer register. It then writes or reads a data window register, which goes to the entry that the pointer selects.

A separate translation port accepts one address per cycle and answers one cycle later. An address inside the aperture, with translation enabled and a valid entry, comes back as the entry's frame joined to the untouched low 12 offset bits, with a hit flag. If the entry is invalid, a fault flag is raised instead. Addresses outside the window, and all addresses while translation is off, come back unchanged. Software clears or restores every entry first, then sets the enable bit. A read of the control register is used as a completion barrier.

Top module: `aper_remap_top`

## Requirements
- R1: After reset the control register reads 0, every table entry reads 0, and translation is disabled.
- R2: Register byte offsets: 0x0 is control, where bit 0 is the translation enable; 0x4 is the entry pointer, which holds a full 32-bit address and reads back as written; 0x8 is the entry data window. Any other offset reads 0, and writes to it change nothing. Read data and reg_rvalid appear one cycle after reg_rd.
- R3: A write to 0x8 stores bit 31 (valid) and bits 30:12 (frame) of the write data into the entry the pointer selects. A later read of 0x8 returns those bits with bits 11:0 as zero.
- R4: While the pointer lies outside the aperture, writes to 0x8 are ignored and reads of 0x8 return 0.
- R5: An address a is inside the aperture when APER_BASE <= a < APER_BASE + NUM_PAGES*4096. Its entry index is (a - APER_BASE) >> 12, so the pointer's low 12 bits do not affect which entry is selected.
- R6: A translation request that is enabled, inside the aperture and on a valid entry returns xl_paddr = {1'b0, frame, addr[11:0]} with xl_hit=1 and xl_fault=0, one cycle after xl_req.
- R7: A translation request that is enabled and inside the aperture, but on an invalid entry, returns xl_fault=1, xl_hit=0 and xl_paddr equal to the request address.
- R8: A translation request outside the aperture, or made while the enable bit is 0, returns the request address unchanged with xl_hit=0 and xl_fault=0.
- R9: Writing 0 to an entry unmaps it. Later translations of that page fault.
- R10: A table or control write takes effect at the clock edge where it is presented. A translation request or control read made in the very next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| xl_req | input | 1 | Translation request |
| xl_addr | input | 32 | Address to translate |
| xl_ovalid | output | 1 | Translation result valid |
| xl_paddr | output | 32 | Translated or passed-through address |
| xl_hit | output | 1 | Mapped page found |
| xl_fault | output | 1 | Page inside the aperture but not mapped |

## Verification
An entry stored at the wrong index, or with the wrong bits masked, shows up on the next read of the data window, which returns in the following cycle. It also shows up on the first translation of that page, which gives a wrong frame or a hit where a fault belongs. A fault in the window comparison shows only at its edges, so requests are aimed at the last byte below the base, at the base, at the last byte of the final page, and at the first byte past it. A stale enable bit or a stale entry after a write is exposed by issuing a translation in the cycle right after the write.

// File: rtl/aper_pkg.sv
package aper_pkg;

   localparam int unsigned APR_WORD_W     = 32;
   localparam int unsigned APR_PAGE_SHIFT = 12;
   localparam int unsigned APR_FRAME_W    = APR_WORD_W - 1 - APR_PAGE_SHIFT;

   typedef struct packed {
      logic                   valid;
      logic [APR_FRAME_W-1:0] frame;
   } apr_entry_t;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_PTR   = 2'd1,
      SEL_DATA  = 2'd2,
      SEL_NONE  = 2'd3
   } apr_sel_t;

   function automatic apr_sel_t apr_decode(input logic [3:0] off);
      case (off)
         4'h0:    return SEL_CTRL;
         4'h4:    return SEL_PTR;
         4'h8:    return SEL_DATA;
         default: return SEL_NONE;
      endcase
   endfunction

   // Window test done one bit wider so that base + span cannot wrap.
   function automatic logic apr_in_window(input logic [31:0] a,
                                          input logic [31:0] base,
                                          input int unsigned pages);
      logic [32:0] lo, hi, av;
      av = {1'b0, a};
      lo = {1'b0, base};
      hi = lo + (33'(pages) << APR_PAGE_SHIFT);
      return (av >= lo) && (av < hi);
   endfunction

   function automatic logic [31:0] apr_page_of(input logic [31:0] a,
                                               input logic [31:0] base);
      return (a - base) >> APR_PAGE_SHIFT;
   endfunction

endpackage

// File: rtl/aper_table.sv
module aper_table
   import aper_pkg::*;
#(
   parameter int unsigned PAGES = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  apr_entry_t       wentry,
   input  logic [IDX_W-1:0] ridx_sw,
   output apr_entry_t       rentry_sw,
   input  logic [IDX_W-1:0] ridx_xl,
   output apr_entry_t       rentry_xl
);

   apr_entry_t mem [PAGES];

   always_ff @(posedge clk) begin
      for (int i = 0; i < PAGES; i++) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (we && (widx == IDX_W'(i)))
            mem[i] <= wentry;
      end
   end

   always_comb begin
      rentry_sw = '0;
      rentry_xl = '0;
      for (int i = 0; i < PAGES; i++) begin
         if (ridx_sw == IDX_W'(i)) rentry_sw = mem[i];
         if (ridx_xl == IDX_W'(i)) rentry_xl = mem[i];
      end
   end

endmodule

// File: rtl/aper_regs.sv
module aper_regs
   import aper_pkg::*;
#(
   parameter logic [31:0] BASE  = 32'h8000_0000,
   parameter int unsigned PAGES = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [3:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             reg_rvalid,
   output logic             xlate_en,
   output logic             tbl_we,
   output logic [IDX_W-1:0] tbl_idx,
   output apr_entry_t       tbl_wentry,
   input  apr_entry_t       tbl_rentry
);

   apr_sel_t    sel;
   logic        en_q;
   logic [31:0] ptr_q;
   logic        ptr_in;
   logic [31:0] rdata_q;
   logic        rvalid_q;
   logic [31:0] rd_mux;

   assign sel    = apr_decode(reg_addr);
   assign ptr_in = apr_in_window(ptr_q, BASE, PAGES);

   assign tbl_idx    = IDX_W'(apr_page_of(ptr_q, BASE));
   assign tbl_we     = reg_wr && (sel == SEL_DATA) && ptr_in;
   assign tbl_wentry = '{valid: reg_wdata[31],
                         frame: reg_wdata[30:APR_PAGE_SHIFT]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ptr_q <= '0;
      end else if (reg_wr) begin
         if (sel == SEL_CTRL) en_q  <= reg_wdata[0];
         if (sel == SEL_PTR)  ptr_q <= reg_wdata;
      end
   end

   always_comb begin
      case (sel)
         SEL_CTRL: rd_mux = {31'b0, en_q};
         SEL_PTR:  rd_mux = ptr_q;
         SEL_DATA: rd_mux = ptr_in ? {tbl_rentry.valid, tbl_rentry.frame,
                                      {APR_PAGE_SHIFT{1'b0}}} : '0;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= reg_rd;
         if (reg_rd) rdata_q <= rd_mux;
      end
   end

   assign reg_rdata  = rdata_q;
   assign reg_rvalid = rvalid_q;
   assign xlate_en   = en_q;

endmodule

// File: rtl/aper_xlate.sv
module aper_xlate
   import aper_pkg::*;
#(
   parameter logic [31:0] BASE    = 32'h8000_0000,
   parameter int unsigned PAGES   = 16,
   parameter int unsigned IDX_W   = 4,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xlate_en,
   input  logic             xl_req,
   input  logic [31:0]      xl_addr,
   output logic [IDX_W-1:0] tbl_idx,
   input  apr_entry_t       tbl_entry,
   output logic             xl_ovalid,
   output logic [31:0]      xl_paddr,
   output logic             xl_hit,
   output logic             xl_fault
);

   logic        in_win;
   logic        hit_c, fault_c;
   logic [31:0] paddr_c;

   assign in_win  = apr_in_window(xl_addr, BASE, PAGES);
   assign tbl_idx = IDX_W'(apr_page_of(xl_addr, BASE));
   assign hit_c   = xl_req && xlate_en && in_win &&  tbl_entry.valid;
   assign fault_c = xl_req && xlate_en && in_win && !tbl_entry.valid;
   assign paddr_c = hit_c ? {1'b0, tbl_entry.frame, xl_addr[APR_PAGE_SHIFT-1:0]}
                          : xl_addr;

   generate
      if (OUT_REG) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               xl_ovalid <= 1'b0;
               xl_paddr  <= '0;
               xl_hit    <= 1'b0;
               xl_fault  <= 1'b0;
            end else begin
               xl_ovalid <= xl_req;
               xl_paddr  <= paddr_c;
               xl_hit    <= hit_c;
               xl_fault  <= fault_c;
            end
         end
      end else begin : g_comb_out
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign xl_ovalid  = xl_req;
         assign xl_paddr   = paddr_c;
         assign xl_hit     = hit_c;
         assign xl_fault   = fault_c;
      end
   endgenerate

endmodule

// File: rtl/aper_remap_top.sv
module aper_remap_top
   import aper_pkg::*;
#(
   parameter logic [31:0] APER_BASE = 32'h8000_0000,
   parameter int unsigned NUM_PAGES = 16,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        reg_rvalid,
   input  logic        xl_req,
   input  logic [31:0] xl_addr,
   output logic        xl_ovalid,
   output logic [31:0] xl_paddr,
   output logic        xl_hit,
   output logic        xl_fault
);

   localparam int unsigned IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
   localparam logic [32:0] SPAN  = 33'(NUM_PAGES) << APR_PAGE_SHIFT;

   generate
      if (NUM_PAGES < 1)
         $error("aper_remap_top: NUM_PAGES must be at least 1");
      if (APER_BASE[APR_PAGE_SHIFT-1:0] != '0)
         $error("aper_remap_top: APER_BASE must be page aligned");
      if (({1'b0, APER_BASE} + SPAN) > 33'h1_0000_0000)
         $error("aper_remap_top: aperture runs past the address space");
   endgenerate

   logic             xlate_en;
   logic             tbl_we;
   logic [IDX_W-1:0] sw_idx, xl_idx;
   apr_entry_t       tbl_wentry, sw_entry, xl_entry;

   aper_regs #(.BASE(APER_BASE), .PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid),
      .xlate_en   (xlate_en),
      .tbl_we     (tbl_we),
      .tbl_idx    (sw_idx),
      .tbl_wentry (tbl_wentry),
      .tbl_rentry (sw_entry)
   );

   aper_table #(.PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (tbl_we),
      .widx      (sw_idx),
      .wentry    (tbl_wentry),
      .ridx_sw   (sw_idx),
      .rentry_sw (sw_entry),
      .ridx_xl   (xl_idx),
      .rentry_xl (xl_entry)
   );

   aper_xlate #(.BASE(APER_BASE), .PAGES(NUM_PAGES), .IDX_W(IDX_W),
                .OUT_REG(OUT_REG)) u_xlate (
      .clk       (clk),
      .rst_n     (rst_n),
      .xlate_en  (xlate_en),
      .xl_req    (xl_req),
      .xl_addr   (xl_addr),
      .tbl_idx   (xl_idx),
      .tbl_entry (xl_entry),
      .xl_ovalid (xl_ovalid),
      .xl_paddr  (xl_paddr),
      .xl_hit    (xl_hit),
      .xl_fault  (xl_fault)
   );

endmodule

// File: rtl/aper_remap_chk.sv
module aper_remap_chk #(
   parameter logic [31:0] BASE    = 32'h8000_0000,
   parameter int unsigned PAGES   = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_rd,
   input logic        reg_rvalid,
   input logic        xl_req,
   input logic [31:0] xl_addr,
   input logic        xl_ovalid,
   input logic [31:0] xl_paddr,
   input logic        xl_hit,
   input logic        xl_fault
);

   logic [31:0] addr_q;
   logic        inwin_q;
   logic [32:0] hi;

   assign hi = {1'b0, BASE} + (33'(PAGES) << 12);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         inwin_q <= 1'b0;
      end else begin
         addr_q  <= xl_addr;
         inwin_q <= ({1'b0, xl_addr} >= {1'b0, BASE}) && ({1'b0, xl_addr} < hi);
      end
   end

   // R2
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);

   // R6
   hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(xl_hit && xl_fault));

   generate
      if (OUT_REG) begin : g_seq
         // R6
         hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (xl_ovalid && xl_hit) |-> (xl_paddr[11:0] == addr_q[11:0]));
         // R7
         fault_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (xl_ovalid && xl_fault) |-> (xl_paddr == addr_q));
         // R8
         outside_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (xl_ovalid && !inwin_q) |-> (!xl_hit && !xl_fault && xl_paddr == addr_q));
         // R6
         ovalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            xl_req |=> xl_ovalid);
      end
   endgenerate

endmodule

bind aper_remap_top aper_remap_chk #(.BASE(APER_BASE), .PAGES(NUM_PAGES),
                                     .OUT_REG(OUT_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_rd     (reg_rd),
   .reg_rvalid (reg_rvalid),
   .xl_req     (xl_req),
   .xl_addr    (xl_addr),
   .xl_ovalid  (xl_ovalid),
   .xl_paddr   (xl_paddr),
   .xl_hit     (xl_hit),
   .xl_fault   (xl_fault)
);

// File: tb/tb_aper_remap_top.sv
module tb_aper_remap_top;

   localparam logic [31:0] BASE  = 32'h8000_0000;
   localparam int unsigned PAGES = 16;
   localparam logic [31:0] PG    = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_rvalid;
   logic        xl_req = 1'b0;
   logic [31:0] xl_addr = '0;
   logic        xl_ovalid;
   logic [31:0] xl_paddr;
   logic        xl_hit, xl_fault;

   int checks = 0;
   int errors = 0;
   logic [31:0] ref_tbl [PAGES];
   logic        ref_en = 1'b0;

   always #2.5 clk = ~clk;

   aper_remap_top #(.APER_BASE(BASE), .NUM_PAGES(PAGES)) dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
      .xl_req(xl_req), .xl_addr(xl_addr), .xl_ovalid(xl_ovalid),
      .xl_paddr(xl_paddr), .xl_hit(xl_hit), .xl_fault(xl_fault)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic in_win(input logic [31:0] a);
      return ({1'b0, a} >= {1'b0, BASE}) && ({1'b0, a} < {1'b0, BASE} + 33'(PAGES) * 33'h1000);
   endfunction

   task automatic reg_write(input logic [3:0] off, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] off, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = off;
      @(negedge clk);
      reg_rd = 1'b0;
      check("R2 rvalid", {31'b0, reg_rvalid}, 32'd1);
      d = reg_rdata;
   endtask

   // Model update: store valid and frame, drop offset bits (R3, R4).
   task automatic map(input logic [31:0] ptr, input logic [31:0] d);
      reg_write(4'h4, ptr);
      reg_write(4'h8, d);
      if (in_win(ptr)) ref_tbl[(ptr - BASE) >> 12] = d & 32'hFFFF_F000;
   endtask

   task automatic xl_check_now(input string req, input logic [31:0] a);
      logic [31:0] e, ep;
      logic eh, ef;
      eh = 1'b0; ef = 1'b0; ep = a;
      if (ref_en && in_win(a)) begin
         e = ref_tbl[(a - BASE) >> 12];
         if (e[31]) begin eh = 1'b1; ep = {1'b0, e[30:12], a[11:0]}; end
         else ef = 1'b1;
      end
      check({req, " ovalid"}, {31'b0, xl_ovalid}, 32'd1);
      check({req, " paddr"}, xl_paddr, ep);
      check({req, " hit"}, {31'b0, xl_hit}, {31'b0, eh});
      check({req, " fault"}, {31'b0, xl_fault}, {31'b0, ef});
   endtask

   task automatic xlate(input string req, input logic [31:0] a);
      @(negedge clk);
      xl_req = 1'b1; xl_addr = a;
      @(negedge clk);
      xl_req = 1'b0;
      xl_check_now(req, a);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      reg_read(4'h0, d);            check("R1 ctrl", d, 32'h0);
      reg_write(4'h4, BASE + 3*PG);
      reg_read(4'h8, d);            check("R1 entry", d, 32'h0);
      xlate("R1 disabled", BASE + 32'h123);
   endtask

   task automatic t_map_readback;
      logic [31:0] d;
      map(BASE, 32'hFFFF_FFFF);
      reg_write(4'h4, BASE);        reg_read(4'h8, d);  check("R3 page0", d, 32'hFFFF_F000);
      map(BASE + 5*PG, 32'h8123_4ABC);
      map(BASE + 3*PG + 32'h77, 32'h0004_5FFF);
      map(BASE + 15*PG, 32'h8765_4000);
      // R5: low pointer bits do not change the selected entry
      reg_write(4'h4, BASE + 5*PG + 32'hFFF);
      reg_read(4'h8, d);            check("R5 index", d, 32'h8123_4000);
      reg_write(4'h4, BASE + 3*PG);
      reg_read(4'h8, d);            check("R3 no-valid", d, 32'h0004_5000);
      reg_write(4'h4, BASE + 15*PG);
      reg_read(4'h8, d);            check("R3 last", d, 32'h8765_4000);
   endtask

   task automatic t_regmap;
      logic [31:0] d;
      reg_write(4'h4, 32'h1234_5678);
      reg_read(4'h4, d);            check("R2 pointer", d, 32'h1234_5678);
      reg_write(4'hC, 32'hFFFF_FFFF);
      reg_write(4'h2, 32'hFFFF_FFFF);
      reg_read(4'hC, d);            check("R2 undecoded read", d, 32'h0);
      reg_read(4'h0, d);            check("R2 ctrl untouched", d, 32'h0);
      reg_read(4'h4, d);            check("R2 pointer untouched", d, 32'h1234_5678);
   endtask

   task automatic t_outside;
      logic [31:0] d;
      reg_write(4'h4, BASE - PG);
      reg_write(4'h8, 32'h8000_1000);
      reg_read(4'h8, d);            check("R4 below read", d, 32'h0);
      reg_write(4'h4, BASE + PAGES*PG);
      reg_write(4'h8, 32'h8000_2000);
      reg_read(4'h8, d);            check("R4 above read", d, 32'h0);
      reg_write(4'h4, BASE);
      reg_read(4'h8, d);            check("R4 page0 kept", d, ref_tbl[0]);
      reg_write(4'h4, BASE + 15*PG);
      reg_read(4'h8, d);            check("R4 page15 kept", d, ref_tbl[15]);
   endtask

   task automatic t_translate;
      logic [31:0] d;
      reg_write(4'h0, 32'h1);       ref_en = 1'b1;
      reg_read(4'h0, d);            check("R2 ctrl enable", d, 32'h1);
      xlate("R6 hit", BASE + 5*PG + 32'h7AB);
      check("R6 value", xl_paddr, 32'h0123_47AB);
      xlate("R7 empty page", BASE + 1*PG + 32'h10);
      xlate("R7 invalid entry", BASE + 3*PG + 32'hFFF);
      xlate("R8 below base", BASE - 1);
      xlate("R6 base", BASE);
      xlate("R6 last byte", BASE + PAGES*PG - 1);
      check("R6 last value", xl_paddr, 32'h0765_4FFF);
      xlate("R8 past end", BASE + PAGES*PG);
   endtask

   task automatic t_unmap_next_cycle;
      // R10: write data at one edge, translate in the next cycle
      reg_write(4'h4, BASE + 5*PG);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h0;
      @(negedge clk);
      reg_wr = 1'b0; ref_tbl[5] = 32'h0;
      xl_req = 1'b1; xl_addr = BASE + 5*PG + 32'h44;
      @(negedge clk);
      xl_req = 1'b0;
      xl_check_now("R9 R10 unmapped", BASE + 5*PG + 32'h44);
      check("R9 fault", {31'b0, xl_fault}, 32'd1);
   endtask

   task automatic t_disable;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0;
      @(negedge clk);
      reg_wr = 1'b0; ref_en = 1'b0;
      xl_req = 1'b1; xl_addr = BASE + 15*PG + 32'h5;
      @(negedge clk);
      xl_req = 1'b0;
      xl_check_now("R8 R10 disabled", BASE + 15*PG + 32'h5);
   endtask

   initial begin
      for (int i = 0; i < PAGES; i++) ref_tbl[i] = 32'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map_readback();
      t_regmap();
      t_outside();
      t_translate();
      t_unmap_next_cycle();
      t_disable();
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule